// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block brings a fast-page DRAM out of power-up and then keeps its cells refreshed. After reset it stays quiet for a programmable pause. It then drives a burst of CAS-before-RAS refresh cycles on its own strobes. Only after that burst does it report the memory as ready. From then on, an interval timer asks for one refresh per programmed period. The refreshes use the CAS-before-RAS ordering, so the DRAM's internal row counter picks the row and no address is driven. Address, write-enable and data lines are left to the access controller, and the data pins stay undriven during a refresh.

In normal operation the scheduler does not take the bus by itself. It raises a request and waits for the access controller to grant the strobes. Refresh periods that pass while the grant is withheld are held in a saturating backlog. When the grant arrives, the whole backlog is issued as back-to-back cycles. A full backlog raises an urgent flag. If the RAS line has been idle for longer than the retention window (no refresh from this block and no activity reported by the controller), the scheduler withdraws its ready flag. It then asks for the bus and repeats the initialization burst.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and in the first cycle after it, ras_n and cas_n are high, and init_done, ref_req, ref_urgent and strobe_own are low.
- R2: For PAUSE_CYC clock cycles after reset is released, ras_n and cas_n both stay high.
- R3: After the pause, exactly INIT_CYCLES refresh cycles are issued without raising ref_req. init_done then rises, with both strobes high, and never rises earlier.
- R4: Every refresh is CAS-before-RAS. cas_n is low for at least CSR_CYC cycles before ras_n falls. It stays low in the cycle ras_n falls, and it rises while ras_n is still low.
- R5: ras_n stays low for at least RAS_LOW_CYC cycles per refresh and high for at least RAS_PRE_CYC cycles between refreshes.
- R6: While init_done is high, a refresh comes due every interval_cfg cycles, with 0 treated as 1. With ref_grant held high, one refresh is issued per period.
- R7: Periods that come due while ref_grant is low are counted. ref_req is high while the count is nonzero or a refresh is in progress. On grant, exactly the counted number of refreshes is issued back to back, and then ref_req falls.
- R8: The count saturates at BACKLOG_MAX, and periods beyond that are dropped. ref_urgent is high exactly while the count equals BACKLOG_MAX.
- R9: After initialization, a refresh starts only while ref_grant is high. strobe_own is high in every cycle where ras_n or cas_n is low.
- R10: Suppose init_done is high and IDLE_LIMIT cycles pass with ras_n high and ctl_ras_act low. Then init_done falls and ref_req rises, and no strobe moves until granted. Once granted, INIT_CYCLES refreshes are issued and init_done rises again. A high ctl_ras_act keeps this from happening.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_cfg | input | IVL_W | Refresh period in clock cycles |
| ctl_ras_act | input | 1 | Access controller is holding RAS low this cycle |
| ref_grant | input | 1 | Access controller hands the strobes to this block |
| ref_req | output | 1 | Block asks for the strobes |
| ref_urgent | output | 1 | Refresh backlog is full |
| init_done | output | 1 | Initialization finished; host accesses allowed |
| strobe_own | output | 1 | This block is driving ras_n and cas_n |
| ras_n | output | 1 | Row strobe from this block, active low |
| cas_n | output | 1 | Column strobe from this block, active low |

## Verification
The assertions assume that the access controller raises ref_grant only while ref_req is high. They also assume that the controller keeps the grant until ref_req falls, so a refresh it has allowed is never cut short. The grant-before-start check depends on this. The stimulus raises grant only in response to a pending request, and it releases grant only after the request has dropped. It also keeps interval_cfg constant within each scenario and well above one refresh length. This keeps every backlog drain and every re-initialization burst separate from the next period.

// File: rtl/dref_pkg.sv
package dref_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_REINIT,
        PH_RUN
    } phase_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_HOLD,
        SQ_RASLO,
        SQ_PRE
    } seq_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
    parameter int unsigned IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IVL_W-1:0] interval,
    output logic             tick
);
    logic [IVL_W-1:0] cnt;
    logic             wrap;

    // period reached; an interval of 0 behaves like 1
    assign wrap = ({1'b0, cnt} + {{IVL_W{1'b0}}, 1'b1}) >= {1'b0, interval};
    assign tick = en && wrap;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dref_backlog.sv
module dref_backlog
    import dref_pkg::*;
#(
    parameter int unsigned MAX_PEND = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic pending,
    output logic urgent
);
    localparam int unsigned CW = cnt_width(MAX_PEND);
    localparam logic [CW-1:0] TOP = CW'(MAX_PEND);

    logic [CW-1:0] cnt;

    assign pending = (cnt != '0);
    assign urgent  = (cnt == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            if (cnt != TOP) begin
                cnt <= cnt + 1'b1;
            end
        end else if (dec && !inc && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP && inc && !dec && !clr) |=> (cnt == TOP));

    // R8
    bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= TOP);

endmodule

// File: rtl/dref_seq.sv
module dref_seq
    import dref_pkg::*;
#(
    parameter int unsigned CSR_CYC     = 1,
    parameter int unsigned CHR_CYC     = 1,
    parameter int unsigned RAS_LOW_CYC = 6,
    parameter int unsigned RAS_PRE_CYC = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output logic    busy,
    output logic    done,
    output strobe_t strb
);
    localparam int unsigned L_SETUP = CSR_CYC - 1;
    localparam int unsigned L_HOLD  = CHR_CYC - 1;
    localparam int unsigned L_RASLO = RAS_LOW_CYC - CHR_CYC - 1;
    localparam int unsigned L_PRE   = RAS_PRE_CYC - 1;
    localparam int unsigned MAXL    = max2(max2(L_SETUP, L_HOLD), max2(L_RASLO, L_PRE));
    localparam int unsigned CW      = cnt_width(MAXL);

    seq_e          state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          last;

    assign last = (cnt == '0);

    always_comb begin
        state_nx = state;
        cnt_nx   = last ? cnt : cnt - 1'b1;
        done     = 1'b0;
        unique case (state)
            SQ_IDLE: if (start) begin
                state_nx = SQ_SETUP;
                cnt_nx   = CW'(L_SETUP);
            end
            SQ_SETUP: if (last) begin
                state_nx = SQ_HOLD;
                cnt_nx   = CW'(L_HOLD);
            end
            SQ_HOLD: if (last) begin
                state_nx = SQ_RASLO;
                cnt_nx   = CW'(L_RASLO);
            end
            SQ_RASLO: if (last) begin
                state_nx = SQ_PRE;
                cnt_nx   = CW'(L_PRE);
            end
            SQ_PRE: if (last) begin
                state_nx = SQ_IDLE;
                done     = 1'b1;
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign busy       = (state != SQ_IDLE);
    assign strb.ras_n = !(state == SQ_HOLD || state == SQ_RASLO);
    assign strb.cas_n = !(state == SQ_SETUP || state == SQ_HOLD);

    // observation counters for the width checks
    logic [7:0] lo_len, hi_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_len <= '0;
            hi_len <= 8'hff;
        end else if (!strb.ras_n) begin
            lo_len <= (lo_len == 8'hff) ? lo_len : lo_len + 1'b1;
            hi_len <= '0;
        end else begin
            lo_len <= '0;
            hi_len <= (hi_len == 8'hff) ? hi_len : hi_len + 1'b1;
        end
    end

    // R4
    cas_before_ras_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ras_n) |-> (!strb.cas_n && !$past(strb.cas_n)));

    // R4
    cas_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.cas_n) |-> !strb.ras_n);

    // R5
    ras_low_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.ras_n) |-> (lo_len >= 8'(RAS_LOW_CYC)));

    // R5
    ras_pre_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.ras_n) |-> (hi_len >= 8'(RAS_PRE_CYC)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dref_pkg::*;
#(
    parameter int unsigned PAUSE_CYC   = 50000,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned BACKLOG_MAX = 8,
    parameter int unsigned IDLE_LIMIT  = 1640000,
    parameter int unsigned IVL_W       = 16,
    parameter int unsigned CSR_CYC     = 1,
    parameter int unsigned CHR_CYC     = 1,
    parameter int unsigned RAS_LOW_CYC = 6,
    parameter int unsigned RAS_PRE_CYC = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IVL_W-1:0] interval_cfg,
    input  logic             ctl_ras_act,
    input  logic             ref_grant,
    output logic             ref_req,
    output logic             ref_urgent,
    output logic             init_done,
    output logic             strobe_own,
    output logic             ras_n,
    output logic             cas_n
);
    localparam int unsigned PW = cnt_width(PAUSE_CYC);
    localparam int unsigned IW = cnt_width(INIT_CYCLES);
    localparam int unsigned DW = cnt_width(IDLE_LIMIT);

    phase_e        phase;
    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] init_left;
    logic [DW-1:0] idle_cnt;
    logic          regrant;

    logic    seq_start, seq_busy, seq_done;
    strobe_t strb;
    logic    tick, pending, urgent;
    logic    run, idle_hit, init_start, run_start;

    assign run      = (phase == PH_RUN);
    assign idle_hit = run && !seq_busy && (idle_cnt == DW'(IDLE_LIMIT));

    assign init_start = (phase == PH_INIT) && (init_left != '0) && !seq_busy
                        && (!regrant || ref_grant);
    assign run_start  = run && ref_grant && pending && !seq_busy && !idle_hit;
    assign seq_start  = init_start || run_start;

    dref_seq #(
        .CSR_CYC    (CSR_CYC),
        .CHR_CYC    (CHR_CYC),
        .RAS_LOW_CYC(RAS_LOW_CYC),
        .RAS_PRE_CYC(RAS_PRE_CYC)
    ) i_seq (
        .clk  (clk),
        .rst  (rst),
        .start(seq_start),
        .busy (seq_busy),
        .done (seq_done),
        .strb (strb)
    );

    dref_timer #(
        .IVL_W(IVL_W)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .en      (run),
        .interval(interval_cfg),
        .tick    (tick)
    );

    dref_backlog #(
        .MAX_PEND(BACKLOG_MAX)
    ) i_backlog (
        .clk    (clk),
        .rst    (rst),
        .clr    (!run),
        .inc    (tick),
        .dec    (run_start),
        .pending(pending),
        .urgent (urgent)
    );

    // phase control
    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PAUSE;
            pause_cnt <= '0;
            init_left <= '0;
            regrant   <= 1'b0;
        end else begin
            unique case (phase)
                PH_PAUSE: begin
                    if (pause_cnt == PW'(PAUSE_CYC - 1)) begin
                        phase     <= PH_INIT;
                        init_left <= IW'(INIT_CYCLES);
                        regrant   <= 1'b0;
                    end else begin
                        pause_cnt <= pause_cnt + 1'b1;
                    end
                end
                PH_INIT: begin
                    if (init_start) begin
                        init_left <= init_left - 1'b1;
                    end else if (init_left == '0 && !seq_busy) begin
                        phase <= PH_RUN;
                    end
                end
                PH_REINIT: begin
                    if (ref_grant) begin
                        phase     <= PH_INIT;
                        init_left <= IW'(INIT_CYCLES);
                        regrant   <= 1'b1;
                    end
                end
                PH_RUN: begin
                    if (idle_hit) begin
                        phase <= PH_REINIT;
                    end
                end
                default: phase <= PH_PAUSE;
            endcase
        end
    end

    // RAS idle watch, active only in normal operation
    always_ff @(posedge clk) begin
        if (rst || !run || !strb.ras_n || ctl_ras_act) begin
            idle_cnt <= '0;
        end else if (idle_cnt != DW'(IDLE_LIMIT)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign init_done  = run;
    assign ref_req    = (phase == PH_REINIT) || ((phase == PH_INIT) && regrant)
                        || (run && (pending || seq_busy));
    assign ref_urgent = urgent;
    assign strobe_own = seq_busy;
    assign ras_n      = strb.ras_n;
    assign cas_n      = strb.cas_n;

    // R2
    pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAUSE) |-> (ras_n && cas_n));

    // R3
    init_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> (ras_n && cas_n && !strobe_own));

    // R9
    own_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> strobe_own);

    // R9
    grant_start_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && init_done) |-> $past(ref_grant));

    // R10
    reinit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REINIT) |-> (ras_n && cas_n && ref_req));

endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;

    localparam int unsigned PAUSE   = 20;
    localparam int unsigned NINIT   = 8;
    localparam int unsigned BMAX    = 8;
    localparam int unsigned IDLE    = 300;
    localparam int unsigned RLOW    = 4;
    localparam int unsigned RPRE    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] interval_cfg = 16'd100;
    logic        ctl_ras_act = 1'b0;
    logic        ref_grant = 1'b0;
    logic        ref_req, ref_urgent, init_done, strobe_own, ras_n, cas_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .PAUSE_CYC  (PAUSE),
        .INIT_CYCLES(NINIT),
        .BACKLOG_MAX(BMAX),
        .IDLE_LIMIT (IDLE),
        .IVL_W      (16),
        .CSR_CYC    (1),
        .CHR_CYC    (1),
        .RAS_LOW_CYC(RLOW),
        .RAS_PRE_CYC(RPRE)
    ) i_dram_refresh_sched (
        .clk         (clk),
        .rst         (rst),
        .interval_cfg(interval_cfg),
        .ctl_ras_act (ctl_ras_act),
        .ref_grant   (ref_grant),
        .ref_req     (ref_req),
        .ref_urgent  (ref_urgent),
        .init_done   (init_done),
        .strobe_own  (strobe_own),
        .ras_n       (ras_n),
        .cas_n       (cas_n)
    );

    // strobe monitor, sampled mid-cycle
    int   falls = 0;
    int   v_cbr = 0;
    int   v_width = 0;
    int   v_own = 0;
    logic p_ras = 1'b1, p_cas = 1'b1;
    int   lo_run = 0, hi_run = 1000, since_fall = 0;

    always @(negedge clk) begin
        if (rst) begin
            p_ras  <= 1'b1;
            p_cas  <= 1'b1;
            lo_run <= 0;
            hi_run <= 1000;
        end else begin
            if (p_ras && !ras_n) begin
                falls <= falls + 1;
                if (cas_n || p_cas) v_cbr <= v_cbr + 1;
                if (hi_run < int'(RPRE)) v_width <= v_width + 1;
                since_fall <= 0;
            end else begin
                since_fall <= since_fall + 1;
            end
            if (!p_ras && ras_n && lo_run < int'(RLOW)) v_width <= v_width + 1;
            if (!p_cas && cas_n && ras_n) v_cbr <= v_cbr + 1;
            if ((!ras_n || !cas_n) && !strobe_own) v_own <= v_own + 1;
            lo_run <= ras_n ? 0 : lo_run + 1;
            hi_run <= ras_n ? hi_run + 1 : 0;
            p_ras  <= ras_n;
            p_cas  <= cas_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst       = 1'b1;
        ref_grant = 1'b0;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic wait_init(input int limit);
        for (int i = 0; i < limit && !init_done; i++) @(negedge clk);
    endtask

    task automatic wait_req(input bit lvl, input int limit);
        for (int i = 0; i < limit && ref_req != lvl; i++) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        cycles(2);
        chk(ras_n && cas_n, "R1 strobes in reset", {ras_n, cas_n}, 3);
        chk(!init_done && !ref_req && !ref_urgent && !strobe_own, "R1 flags in reset",
            {init_done, ref_req, ref_urgent, strobe_own}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ras_n && cas_n && !init_done && !ref_req, "R1 first cycle after reset",
            {ras_n, cas_n, init_done, ref_req}, 12);
    endtask

    // R2, R3
    task automatic t_powerup();
        int bad = 0;
        int reqs = 0;
        int base;
        interval_cfg = 16'd100;
        do_reset();
        base = falls;
        for (int i = 0; i < int'(PAUSE); i++) begin
            if (!ras_n || !cas_n) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 strobes quiet during pause", bad, 0);
        for (int i = 0; i < 400 && !init_done; i++) begin
            if (ref_req) reqs++;
            @(negedge clk);
        end
        chk(init_done == 1'b1, "R3 init_done rises", init_done, 1);
        chk(reqs == 0, "R3 no request during power-up burst", reqs, 0);
        chk(falls - base == int'(NINIT), "R3 init cycle count", falls - base, NINIT);
        chk(ras_n && cas_n, "R3 strobes high at init_done", {ras_n, cas_n}, 3);
    endtask

    // R6
    task automatic t_periodic();
        int base;
        int urg = 0;
        interval_cfg = 16'd40;
        ctl_ras_act  = 1'b0;
        do_reset();
        wait_init(400);
        ref_grant = 1'b1;
        base = falls;
        for (int i = 0; i < 400; i++) begin
            if (ref_urgent) urg++;
            @(negedge clk);
        end
        chk((falls - base) >= 9 && (falls - base) <= 10, "R6 one refresh per period",
            falls - base, 10);
        chk(urg == 0, "R6 no urgent when granted", urg, 0);
        chk(init_done == 1'b1, "R6 stays initialized", init_done, 1);
        ref_grant = 1'b0;
        wait_req(1'b0, 50);
    endtask

    // R7
    task automatic t_backlog();
        int base;
        interval_cfg = 16'd100;
        ctl_ras_act  = 1'b1;
        do_reset();
        wait_init(400);
        chk(ref_req == 1'b0, "R7 no request before first period", ref_req, 0);
        wait_req(1'b1, 200);
        cycles(205);
        chk(ref_req == 1'b1 && ref_urgent == 1'b0, "R7 request held without grant",
            {ref_req, ref_urgent}, 2);
        base = falls;
        chk(falls - base == 0, "R7 nothing issued before grant", falls - base, 0);
        ref_grant = 1'b1;
        wait_req(1'b0, 200);
        chk(falls - base == 3, "R7 backlog drained", falls - base, 3);
        chk(ras_n && cas_n, "R7 strobes idle after drain", {ras_n, cas_n}, 3);
        ref_grant = 1'b0;
        cycles(10);
        chk(falls - base == 3, "R7 no extra refresh", falls - base, 3);
    endtask

    // R8
    task automatic t_saturate();
        int base;
        interval_cfg = 16'd100;
        ctl_ras_act  = 1'b1;
        do_reset();
        wait_init(400);
        wait_req(1'b1, 200);
        cycles(605);
        chk(ref_urgent == 1'b0, "R8 urgent low at seven pending", ref_urgent, 0);
        cycles(100);
        chk(ref_urgent == 1'b1, "R8 urgent high at limit", ref_urgent, 1);
        cycles(200);
        chk(ref_urgent == 1'b1, "R8 urgent held while saturated", ref_urgent, 1);
        base = falls;
        ref_grant = 1'b1;
        wait_req(1'b0, 300);
        chk(falls - base == int'(BMAX), "R8 saturated count issued", falls - base, BMAX);
        chk(ref_urgent == 1'b0, "R8 urgent cleared", ref_urgent, 0);
        chk(init_done == 1'b1, "R10 controller activity keeps init", init_done, 1);
        ref_grant = 1'b0;
        ctl_ras_act = 1'b0;
    endtask

    // R10, R9
    task automatic t_idle();
        int base;
        interval_cfg = 16'd100;
        ctl_ras_act  = 1'b0;
        do_reset();
        wait_init(400);
        base = falls;
        cycles(250);
        chk(init_done == 1'b1, "R10 still initialized before limit", init_done, 1);
        cycles(70);
        chk(init_done == 1'b0, "R10 init dropped after idle", init_done, 0);
        chk(ref_req == 1'b1, "R10 request for re-init", ref_req, 1);
        cycles(30);
        chk(falls - base == 0, "R9 no refresh without grant", falls - base, 0);
        ref_grant = 1'b1;
        wait_init(300);
        chk(init_done == 1'b1, "R10 init restored", init_done, 1);
        chk(falls - base == int'(NINIT), "R10 re-init cycle count", falls - base, NINIT);
        @(negedge clk);
        chk(ref_req == 1'b0, "R10 request released", ref_req, 0);
        ref_grant = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_periodic();
        t_backlog();
        t_saturate();
        t_idle();
        chk(v_cbr == 0, "R4 CAS-before-RAS ordering", v_cbr, 0);
        chk(v_width == 0, "R5 RAS low and precharge widths", v_width, 0);
        chk(v_own == 0, "R9 strobe_own covers strobes", v_own, 0);
        summary();
    end

    initial begin
        cycles(60000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 60000, 0);
        summary();
    end

endmodule